// File: doc/BRIEF.md
# Guarded Register Write Sequencer

This block sits between a host write port and a register block that runs from a slow clock and can lose writes. Each accepted host request becomes a fixed burst on the register-side port: two writes of zero to the status register, then the requested write. After that burst the sequencer keeps the register side quiet for a settling time and refuses new requests until that time is over.

The host side uses a valid/ready handshake. A request that arrives while the sequencer is busy is held off, not dropped. The requester keeps `req_valid` high, and the request is taken in the first idle cycle. The address and data are captured when the request is accepted, so later changes on the request inputs do not affect the burst in progress.

The settling time is given in nanoseconds. It is converted to a cycle count from the clock-frequency parameter and rounded up, with a minimum of one cycle.

The state machine has five states:

- `ST_IDLE` (ready).
- `ST_PRIME_A` (first zero write to status).
- `ST_PRIME_B` (second zero write to status).
- `ST_COMMIT` (the requested write).
- `ST_SETTLE` (hold-off).

Its transitions are:

- idle→prime_a when a request is accepted.
- prime_a→prime_b unconditionally.
- prime_b→commit unconditionally.
- commit→settle unconditionally.
- settle→settle while the hold-off counter is not zero.
- settle→idle when the hold-off counter is zero.

Top module: `guarded_write_seq`

## Requirements
- R1: While reset is active and in the first cycle after it, `busy` is 0, `req_ready` is 1 and `wr_en` is 0.
- R2: `req_ready` is 1 exactly when `busy` is 0. A request is accepted on a rising edge where both `req_valid` and `req_ready` are 1, and `busy` is 1 from the next cycle on.
- R3: In the first cycle after acceptance, `wr_en` is 1, `wr_addr` equals `STATUS_ADDR` (default 0) and `wr_data` is all zeros.
- R4: In the second cycle after acceptance, a second identical beat is issued: `wr_en` is 1, `wr_addr` is `STATUS_ADDR` and `wr_data` is zero.
- R5: In the third cycle after acceptance, `wr_en` is 1 and `wr_addr` and `wr_data` carry the address and data that were present at acceptance.
- R6: For the `HOLD_CYC` = ceil(`CLK_MHZ`·`HOLD_NS`/1000) cycles after the requested write (at least 1), `wr_en` is 0 and `busy` stays 1.
- R7: `busy` falls right after those `HOLD_CYC` cycles. A request that is already waiting is accepted in that first idle cycle, so accepted requests are spaced 4+`HOLD_CYC` cycles apart.
- R8: A request presented while `busy` is 1 is not accepted and not lost. With `req_valid` held, it is accepted when the sequencer returns to idle. Changes to `req_addr` or `req_data` after acceptance do not alter the beats.
- R9: `wr_en` is 1 only while `busy` is 1. Each beat lasts one cycle, and no more than three beats come on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host write request present |
| req_ready | output | 1 | Sequencer can accept a request |
| req_addr | input | ADDR_W | Host write offset |
| req_data | input | DATA_W | Host write data |
| busy | output | 1 | Sequence or hold-off in progress |
| wr_en | output | 1 | One-cycle write strobe to the register block |
| wr_addr | output | ADDR_W | Register-side write offset |
| wr_data | output | DATA_W | Register-side write data |

## Verification
The bench builds the block with an 8-bit address, 16-bit data, `CLK_MHZ` = 2 and `HOLD_NS` = 5000. This gives a ten-cycle hold-off instead of a thousand, so many complete sequences fit in a short run. With that short window, back-to-back requests, requests stalled through the whole settle phase, and requester pulses that are withdrawn before idle can all be exercised. A nonzero `STATUS_ADDR` can be set to tell the dummy beats apart from host writes to offset zero. The default of zero keeps the case where a host write to the status offset can only be told apart by its data.

// File: rtl/gws_pkg.sv
package gws_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_PRIME_A = 3'd1,
        ST_PRIME_B = 3'd2,
        ST_COMMIT  = 3'd3,
        ST_SETTLE  = 3'd4
    } gws_state_e;

    // Hold-off in cycles: ns * MHz / 1000, rounded up, never below one.
    function automatic int unsigned hold_cycles(input int unsigned clk_mhz,
                                                input int unsigned hold_ns);
        int unsigned c;
        c = (clk_mhz * hold_ns + 999) / 1000;
        return (c == 0) ? 1 : c;
    endfunction

endpackage

// File: rtl/gws_fsm.sv
module gws_fsm
    import gws_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       hold_done,
    output gws_state_e state
);

    gws_state_e state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (req_valid) state_nx = ST_PRIME_A;
            ST_PRIME_A: state_nx = ST_PRIME_B;
            ST_PRIME_B: state_nx = ST_COMMIT;
            ST_COMMIT:  state_nx = ST_SETTLE;
            ST_SETTLE:  if (hold_done) state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

endmodule

// File: rtl/gws_holdoff.sv
module gws_holdoff #(
    parameter int unsigned HOLD_CYC = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic done
);

    localparam int unsigned CNT_W = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(HOLD_CYC - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= LOAD_VAL;
        else if (run && cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);

endmodule

// File: rtl/gws_capture.sv
module gws_capture #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_data,
    output logic [ADDR_W-1:0] held_addr,
    output logic [DATA_W-1:0] held_data
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_addr <= '0;
            held_data <= '0;
        end else if (take) begin
            held_addr <= in_addr;
            held_data <= in_data;
        end
    end

endmodule

// File: rtl/guarded_write_seq.sv
module guarded_write_seq
    import gws_pkg::*;
#(
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned CLK_MHZ     = 200,
    parameter int unsigned HOLD_NS     = 5000,
    parameter int unsigned STATUS_ADDR = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    output logic              busy,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);

    localparam int unsigned HOLD_CYC = hold_cycles(CLK_MHZ, HOLD_NS);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STATUS_ADDR);

    gws_state_e        state;
    logic              hold_done;
    logic              accept;
    logic [ADDR_W-1:0] held_addr;
    logic [DATA_W-1:0] held_data;

    assign accept = req_valid && (state == ST_IDLE);

    gws_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .hold_done (hold_done),
        .state     (state)
    );

    gws_holdoff #(.HOLD_CYC(HOLD_CYC)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (state == ST_COMMIT),
        .run   (state == ST_SETTLE),
        .done  (hold_done)
    );

    gws_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (accept),
        .in_addr   (req_addr),
        .in_data   (req_data),
        .held_addr (held_addr),
        .held_data (held_data)
    );

    // Output decode from the state register.
    always_comb begin
        req_ready = 1'b0;
        busy      = 1'b1;
        wr_en     = 1'b0;
        wr_addr   = '0;
        wr_data   = '0;
        unique case (state)
            ST_IDLE: begin
                req_ready = 1'b1;
                busy      = 1'b0;
            end
            ST_PRIME_A, ST_PRIME_B: begin
                wr_en   = 1'b1;
                wr_addr = STAT_A;
            end
            ST_COMMIT: begin
                wr_en   = 1'b1;
                wr_addr = held_addr;
                wr_data = held_data;
            end
            ST_SETTLE: ;
            default: begin
                busy = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/gws_checker.sv
module gws_checker
    import gws_pkg::*;
#(
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned CLK_MHZ     = 200,
    parameter int unsigned HOLD_NS     = 5000,
    parameter int unsigned STATUS_ADDR = 0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr,
    input logic [DATA_W-1:0] req_data,
    input logic              busy,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data
);

    localparam int unsigned HOLD_CYC = hold_cycles(CLK_MHZ, HOLD_NS);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STATUS_ADDR);

    int unsigned quiet_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)     quiet_cnt <= 0;
        else if (wr_en) quiet_cnt <= 0;
        else if (busy)  quiet_cnt <= quiet_cnt + 1;
        else            quiet_cnt <= 0;
    end

    a_r2_ready_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready == !busy);

    a_r3_first_prime: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (wr_en && wr_addr == STAT_A && wr_data == '0));

    a_r4_second_prime: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> ##1 (wr_en && wr_addr == STAT_A && wr_data == '0));

    a_r5_commit_beat: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> ##2 (wr_en && wr_addr == $past(req_addr, 3)
                                                && wr_data == $past(req_data, 3)));

    a_r6_quiet_settle: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !wr_en) |-> (quiet_cnt < HOLD_CYC));

    a_r7_release_time: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (quiet_cnt == HOLD_CYC));

    a_r9_strobe_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> busy);

    a_r9_max_three_beats: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en) && $past(wr_en, 2)) |=> !wr_en);

endmodule

bind guarded_write_seq gws_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CLK_MHZ(CLK_MHZ),
    .HOLD_NS(HOLD_NS), .STATUS_ADDR(STATUS_ADDR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_data(req_data), .busy(busy), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data)
);

// File: tb/sim_guarded_write_seq.sv
`timescale 1ns/1ps
module sim_guarded_write_seq;

    localparam int AW = 8;
    localparam int DW = 16;
    localparam int HOLD = 10;     // ceil(2 MHz * 5000 ns / 1000)
    localparam int STAT = 8'h00;

    typedef struct packed {
        logic          en;
        logic [AW-1:0] a;
        logic [DW-1:0] d;
    } beat_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_data = '0;
    logic          req_ready, busy, wr_en;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;

    int checks = 0;
    int fails  = 0;
    int beats_seen = 0;
    int sends = 0;

    beat_t exp_q[$];
    string tag_q[$];

    always #2.5 clk = ~clk;

    guarded_write_seq #(
        .ADDR_W(AW), .DATA_W(DW), .CLK_MHZ(2), .HOLD_NS(5000), .STATUS_ADDR(STAT)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_data(req_data), .busy(busy), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data)
    );

    // Behavioural reference: a queue of expected per-cycle outputs.
    always @(posedge clk) begin
        if (!rst_n) begin
            exp_q.delete();
            tag_q.delete();
        end else if (exp_q.size() != 0) begin
            void'(exp_q.pop_front());
            void'(tag_q.pop_front());
        end else if (req_valid) begin
            exp_q.push_back('{1'b1, AW'(STAT), '0});   tag_q.push_back("R3");
            exp_q.push_back('{1'b1, AW'(STAT), '0});   tag_q.push_back("R4");
            exp_q.push_back('{1'b1, req_addr, req_data}); tag_q.push_back("R5");
            for (int i = 0; i < HOLD; i++) begin
                exp_q.push_back('{1'b0, '0, '0});
                tag_q.push_back("R6");
            end
        end
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Per-cycle comparison away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            beat_t e;
            string t;
            bit    eb;
            eb = (exp_q.size() != 0);
            e  = eb ? exp_q[0] : '{1'b0, '0, '0};
            t  = eb ? tag_q[0] : "R7";
            if (wr_en) beats_seen++;
            check(busy == eb, eb ? t : "R7", "busy", busy, eb);
            check(req_ready == !eb, "R2", "req_ready", req_ready, !eb);
            check(wr_en == e.en, e.en ? t : "R9", "wr_en", wr_en, e.en);
            if (e.en) begin
                check(wr_addr == e.a, t, "wr_addr", wr_addr, e.a);
                check(wr_data == e.d, t, "wr_data", wr_data, e.d);
            end
        end
    end

    // Present a request, hold it until taken, then scramble the inputs (R8).
    task automatic send(input logic [AW-1:0] a, input logic [DW-1:0] d);
        bit took;
        req_valid = 1'b1;
        req_addr  = a;
        req_data  = d;
        sends++;
        forever begin
            took = req_ready;
            @(negedge clk);
            if (took) break;
        end
        req_valid = 1'b0;
        req_addr  = ~a;
        req_data  = ~d;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R1: outputs during reset
        check(busy == 1'b0, "R1", "busy in reset", busy, 0);
        check(req_ready == 1'b1, "R1", "ready in reset", req_ready, 1);
        check(wr_en == 1'b0, "R1", "wr_en in reset", wr_en, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && req_ready && !wr_en, "R1", "idle after reset",
              {busy, req_ready, wr_en}, 3'b010);

        // Single write, then idle gap
        send(8'h24, 16'hBEEF);
        repeat (HOLD + 6) @(negedge clk);

        // Write to status offset with nonzero data, all-ones pattern
        send(8'h00, 16'h1234);
        send(8'hFF, 16'hFFFF);           // stalled behind previous (R8)
        send(8'h81, 16'h0000);           // back to back (R7)
        repeat (2) @(negedge clk);

        // R2: pulse valid while busy, withdraw before idle: nothing accepted
        req_valid = 1'b1; req_addr = 8'h55; req_data = 16'hAAAA;
        repeat (2) @(negedge clk);
        req_valid = 1'b0;
        repeat (HOLD + 8) @(negedge clk);
        check(!busy, "R2", "withdrawn pulse not taken", busy, 0);

        // Long stalled chain
        for (int k = 0; k < 4; k++) send(AW'(8'h10 + k), DW'(16'h0F00 * (k + 1)));
        repeat (HOLD + 6) @(negedge clk);

        // R8 and R9: every accepted request produced exactly three beats
        check(beats_seen == 3 * sends, "R8", "beat count", beats_seen, 3 * sends);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule